// File: doc/BRIEF.md
# Zoned External Bus Controller

This block turns single requests from an internal master into timed cycles on an asynchronous external memory bus. Each request carries a three-bit zone number. The zone chooses which active-low chip select is driven. Zones 0 and 1 share one select, zone 2 has its own, and zones 6 and 7 share a third. The zone also chooses how the access is timed. Every zone has its own programmed lead, active and trail lengths, and its own choice of whether the ready input is taken directly or through a synchronizer. The read and write strobes are low only during the active phase. The active phase is stretched for as long as the peripheral holds ready low at its programmed end. The controller returns one response pulse per request, with read data when the request was a read.

Zone 7 is enabled by a configuration bit. That bit takes the value of a mode pin while reset is asserted, and a later configuration write can change it. Changes on the pin after reset have no effect. A request to zone 7 while it is disabled is not sent off-chip, and neither is a request to a zone with no select. Another bus master can ask for the bus with an active-low hold request. The controller first finishes the access in progress and any request already waiting at its port. It then drops its single pad output-enable and answers with an active-low acknowledge. The acknowledge stays low until the hold request goes away.

Top module: `ext_bus_zone_ctrl`

## Requirements
- R1: While reset is asserted, the zone 7 enable bit takes the value of `boot_mode_i`. After reset, changes on that pin have no effect. A cycle with `z7_we_i` high loads `z7_d_i` into the bit.
- R2: After a synchronized hold request is granted, `holda_n_o`, `bus_oe_o` and `xd_oe_o` are all low. `holda_n_o` goes high again only after the synchronized hold request has been deasserted.
- R3: A hold is granted only from idle. An access in progress runs through its trail phase first, and a request that is valid while the controller is idle is accepted ahead of the hold.
- R4: Zones 0 and 1 drive `cs01_n_o`, zone 2 drives `cs2_n_o`, and zones 6 and 7 drive `cs67_n_o`. The select is low from the first lead cycle to the last trail cycle, and at most one select is low at a time.
- R5: An access has lead, active and trail phases of L, A and T cycles. These values come from the zone's fields in `lead_cfg_i`, `act_cfg_i` and `trail_cfg_i`, where zone z occupies bits [z*TW +: TW], and a field value of 0 counts as 1. A read pulses `rd_n_o` low and a write pulses `wr_n_o` low, only in the active phase.
- R6: `rd_n_o` and `wr_n_o` are never low together.
- R7: `rnw_o` is high except from lead to trail of a write.
- R8: If the effective ready is low at the last programmed active cycle, the active phase grows by one cycle at a time. When `rdy_async_i` bit z is 0, zone z uses `ready_i` directly. When the bit is 1, zone z uses `ready_i` through a two-flop synchronizer, which adds two cycles of latency.
- R9: `req_ready_o` is high only while the controller is idle, never during an access or a hold. A request is accepted on a clock edge where both `req_valid_i` and `req_ready_o` are high.
- R10: A write drives `xd_o` with the write data, with `xd_oe_o` high, from lead to trail. A read samples `xd_i` on its last active cycle. `rsp_valid_o` then pulses for one cycle in the cycle after the trail phase ends, with that data on `rsp_rdata_o`.
- R11: A request to zone 3, 4 or 5, or to zone 7 while it is disabled, starts no bus cycle. `rsp_valid_o` and `rsp_err_o` both pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_mode_i | input | 1 | Zone 7 enable value, sampled while reset is asserted |
| z7_we_i | input | 1 | Write strobe for the zone 7 enable bit |
| z7_d_i | input | 1 | New value for the zone 7 enable bit |
| lead_cfg_i | input | 8*TW | Lead length per zone |
| act_cfg_i | input | 8*TW | Active length per zone |
| trail_cfg_i | input | 8*TW | Trail length per zone |
| rdy_async_i | input | 8 | Per zone: 1 = synchronize ready first |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_zone_i | input | 3 | Target zone |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Request was not sent to the bus |
| rsp_rdata_o | output | DW | Read data |
| xa_o | output | AW | External address |
| xd_o | output | DW | External write data |
| xd_i | input | DW | External read data |
| xd_oe_o | output | 1 | Data pad output enable |
| bus_oe_o | output | 1 | Output enable for address, select and strobe pads |
| cs01_n_o | output | 1 | Select for zones 0 and 1, active low |
| cs2_n_o | output | 1 | Select for zone 2, active low |
| cs67_n_o | output | 1 | Select for zones 6 and 7, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| rnw_o | output | 1 | High for read or idle, low during a write cycle |
| ready_i | input | 1 | Peripheral ready, active high |
| hold_n_i | input | 1 | Hold request, active low |
| holda_n_o | output | 1 | Hold acknowledge, active low |

## Verification
Zone field values of zero are run beside multi-cycle settings. A design that skips a phase shows up as a select or strobe window one cycle short. Ready is held low past the programmed active end, in a direct zone and in a synchronized zone. A controller that ignores ready, or uses the wrong path for a zone, ends the strobe at the wrong cycle. A hold is raised in the middle of a write, and requests are presented during the hold. A design that gives up the bus early, or accepts work while holding, lowers the acknowledge inside the access or opens a select. Zone 7 is tried first with the pin low, then after the pin rises, and then after a configuration write. A design that keeps sampling the pin after reset lets the second try reach the bus.

// File: rtl/ebz_pkg.sv
package ebz_pkg;

   localparam int NZONE = 8;
   localparam int ZW    = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_ACT,
      ST_TRAIL,
      ST_HOLD
   } ebz_state_e;

   typedef enum logic [1:0] {
      GRP_NONE,
      GRP_Z01,
      GRP_Z2,
      GRP_Z67
   } ebz_grp_e;

   function automatic ebz_grp_e zone_group(input logic [ZW-1:0] z);
      ebz_grp_e g;
      case (z)
         3'd0, 3'd1: g = GRP_Z01;
         3'd2:       g = GRP_Z2;
         3'd6, 3'd7: g = GRP_Z67;
         default:    g = GRP_NONE;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/ebz_sync.sv
module ebz_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= {STAGES{RST_VAL}};
            end else begin
               r[0] <= d;
               for (int i = 1; i < STAGES; i++) begin
                  r[i] <= r[i-1];
               end
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ebz_zone_cfg.sv
module ebz_zone_cfg
   import ebz_pkg::*;
#(
   parameter int TW = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                boot_mode_i,
   input  logic                z7_we_i,
   input  logic                z7_d_i,
   input  logic [NZONE*TW-1:0] lead_cfg_i,
   input  logic [NZONE*TW-1:0] act_cfg_i,
   input  logic [NZONE*TW-1:0] trail_cfg_i,
   input  logic [NZONE-1:0]    rdy_async_i,
   input  logic [ZW-1:0]       zone_i,
   output logic                mapped_o,
   output logic [TW-1:0]       lead_m1_o,
   output logic [TW-1:0]       act_m1_o,
   output logic [TW-1:0]       trail_m1_o,
   output logic                async_o
);

   logic          z7_en;
   logic [TW-1:0] lead_m1  [NZONE];
   logic [TW-1:0] act_m1   [NZONE];
   logic [TW-1:0] trail_m1 [NZONE];

   // Zone 7 enable: follows the mode pin only while reset is held.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         z7_en <= boot_mode_i;
      end else if (z7_we_i) begin
         z7_en <= z7_d_i;
      end
   end

   // Per-zone phase lengths, stored as length minus one; zero counts as one.
   generate
      for (genvar z = 0; z < NZONE; z++) begin : g_zone
         logic [TW-1:0] lv, av, tv;
         assign lv = lead_cfg_i [z*TW +: TW];
         assign av = act_cfg_i  [z*TW +: TW];
         assign tv = trail_cfg_i[z*TW +: TW];
         assign lead_m1[z]  = (lv == '0) ? '0 : lv - 1'b1;
         assign act_m1[z]   = (av == '0) ? '0 : av - 1'b1;
         assign trail_m1[z] = (tv == '0) ? '0 : tv - 1'b1;
      end
   endgenerate

   assign lead_m1_o  = lead_m1[zone_i];
   assign act_m1_o   = act_m1[zone_i];
   assign trail_m1_o = trail_m1[zone_i];
   assign async_o    = rdy_async_i[zone_i];

   always_comb begin
      mapped_o = (zone_group(zone_i) != GRP_NONE);
      if (zone_i == 3'd7 && !z7_en) begin
         mapped_o = 1'b0;
      end
   end

endmodule

// File: rtl/ebz_seq.sv
module ebz_seq
   import ebz_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16,
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid_i,
   input  logic          req_write_i,
   input  logic [ZW-1:0] req_zone_i,
   input  logic [AW-1:0] req_addr_i,
   input  logic [DW-1:0] req_wdata_i,
   input  logic          mapped_i,
   input  logic [TW-1:0] lead_m1_i,
   input  logic [TW-1:0] act_m1_i,
   input  logic [TW-1:0] trail_m1_i,
   input  logic          async_i,
   input  logic          ready_i,
   input  logic          ready_sync_i,
   input  logic          hold_req_i,
   input  logic [DW-1:0] xd_i,
   output logic          req_ready_o,
   output logic          rsp_valid_o,
   output logic          rsp_err_o,
   output logic [DW-1:0] rsp_rdata_o,
   output logic [AW-1:0] xa_o,
   output logic [DW-1:0] xd_o,
   output logic          xd_oe_o,
   output logic          bus_oe_o,
   output logic          cs01_n_o,
   output logic          cs2_n_o,
   output logic          cs67_n_o,
   output logic          rd_n_o,
   output logic          wr_n_o,
   output logic          rnw_o,
   output logic          holda_n_o
);

   ebz_state_e    state;
   logic [TW-1:0] cnt;
   logic [ZW-1:0] cur_zone;
   logic          cur_wr;
   logic [AW-1:0] cur_addr;
   logic [DW-1:0] cur_wdata;
   logic [TW-1:0] cur_act_m1;
   logic [TW-1:0] cur_trail_m1;
   logic          cur_async;
   logic [DW-1:0] rdata_q;
   logic          rsp_v_q;
   logic          rsp_e_q;
   logic          busy;
   logic          rdy_eff;
   ebz_grp_e      grp;

   assign rdy_eff = cur_async ? ready_sync_i : ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         cnt          <= '0;
         cur_zone     <= '0;
         cur_wr       <= 1'b0;
         cur_addr     <= '0;
         cur_wdata    <= '0;
         cur_act_m1   <= '0;
         cur_trail_m1 <= '0;
         cur_async    <= 1'b0;
         rdata_q      <= '0;
         rsp_v_q      <= 1'b0;
         rsp_e_q      <= 1'b0;
      end else begin
         rsp_v_q <= 1'b0;
         rsp_e_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid_i) begin
                  if (mapped_i) begin
                     state        <= ST_LEAD;
                     cnt          <= lead_m1_i;
                     cur_zone     <= req_zone_i;
                     cur_wr       <= req_write_i;
                     cur_addr     <= req_addr_i;
                     cur_wdata    <= req_wdata_i;
                     cur_act_m1   <= act_m1_i;
                     cur_trail_m1 <= trail_m1_i;
                     cur_async    <= async_i;
                  end else begin
                     rsp_v_q <= 1'b1;
                     rsp_e_q <= 1'b1;
                  end
               end else if (hold_req_i) begin
                  state <= ST_HOLD;
               end
            end
            ST_LEAD: begin
               if (cnt == '0) begin
                  state <= ST_ACT;
                  cnt   <= cur_act_m1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_ACT: begin
               if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else if (rdy_eff) begin
                  state <= ST_TRAIL;
                  cnt   <= cur_trail_m1;
                  if (!cur_wr) begin
                     rdata_q <= xd_i;
                  end
               end
            end
            ST_TRAIL: begin
               if (cnt == '0) begin
                  state   <= ST_IDLE;
                  rsp_v_q <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_HOLD: begin
               if (!hold_req_i) begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state == ST_LEAD) || (state == ST_ACT) || (state == ST_TRAIL);
   assign grp  = zone_group(cur_zone);

   assign req_ready_o = (state == ST_IDLE);
   assign rsp_valid_o = rsp_v_q;
   assign rsp_err_o   = rsp_e_q;
   assign rsp_rdata_o = rdata_q;
   assign xa_o        = cur_addr;
   assign xd_o        = cur_wdata;
   assign xd_oe_o     = busy && cur_wr;
   assign bus_oe_o    = (state != ST_HOLD);
   assign holda_n_o   = (state != ST_HOLD);
   assign cs01_n_o    = !(busy && grp == GRP_Z01);
   assign cs2_n_o     = !(busy && grp == GRP_Z2);
   assign cs67_n_o    = !(busy && grp == GRP_Z67);
   assign rd_n_o      = !((state == ST_ACT) && !cur_wr);
   assign wr_n_o      = !((state == ST_ACT) && cur_wr);
   assign rnw_o       = !(busy && cur_wr);

endmodule

// File: rtl/ext_bus_zone_ctrl.sv
module ext_bus_zone_ctrl
   import ebz_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 16,
   parameter int TW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                boot_mode_i,
   input  logic                z7_we_i,
   input  logic                z7_d_i,
   input  logic [NZONE*TW-1:0] lead_cfg_i,
   input  logic [NZONE*TW-1:0] act_cfg_i,
   input  logic [NZONE*TW-1:0] trail_cfg_i,
   input  logic [NZONE-1:0]    rdy_async_i,
   input  logic                req_valid_i,
   output logic                req_ready_o,
   input  logic                req_write_i,
   input  logic [ZW-1:0]       req_zone_i,
   input  logic [AW-1:0]       req_addr_i,
   input  logic [DW-1:0]       req_wdata_i,
   output logic                rsp_valid_o,
   output logic                rsp_err_o,
   output logic [DW-1:0]       rsp_rdata_o,
   output logic [AW-1:0]       xa_o,
   output logic [DW-1:0]       xd_o,
   input  logic [DW-1:0]       xd_i,
   output logic                xd_oe_o,
   output logic                bus_oe_o,
   output logic                cs01_n_o,
   output logic                cs2_n_o,
   output logic                cs67_n_o,
   output logic                rd_n_o,
   output logic                wr_n_o,
   output logic                rnw_o,
   input  logic                ready_i,
   input  logic                hold_n_i,
   output logic                holda_n_o
);

   generate
      if (AW < 1) begin : g_bad_aw
         $error("AW must be at least 1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be at least 1");
      end
      if (TW < 1 || TW > 16) begin : g_bad_tw
         $error("TW must be in 1..16");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic          hold_n_s;
   logic          hold_req;
   logic          ready_s;
   logic          mapped;
   logic [TW-1:0] lead_m1;
   logic [TW-1:0] act_m1;
   logic [TW-1:0] trail_m1;
   logic          zasync;

   ebz_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hold_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (hold_n_i),
      .q     (hold_n_s)
   );

   ebz_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ready_i),
      .q     (ready_s)
   );

   assign hold_req = !hold_n_s;

   ebz_zone_cfg #(.TW(TW)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .boot_mode_i (boot_mode_i),
      .z7_we_i     (z7_we_i),
      .z7_d_i      (z7_d_i),
      .lead_cfg_i  (lead_cfg_i),
      .act_cfg_i   (act_cfg_i),
      .trail_cfg_i (trail_cfg_i),
      .rdy_async_i (rdy_async_i),
      .zone_i      (req_zone_i),
      .mapped_o    (mapped),
      .lead_m1_o   (lead_m1),
      .act_m1_o    (act_m1),
      .trail_m1_o  (trail_m1),
      .async_o     (zasync)
   );

   ebz_seq #(.AW(AW), .DW(DW), .TW(TW)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid_i),
      .req_write_i  (req_write_i),
      .req_zone_i   (req_zone_i),
      .req_addr_i   (req_addr_i),
      .req_wdata_i  (req_wdata_i),
      .mapped_i     (mapped),
      .lead_m1_i    (lead_m1),
      .act_m1_i     (act_m1),
      .trail_m1_i   (trail_m1),
      .async_i      (zasync),
      .ready_i      (ready_i),
      .ready_sync_i (ready_s),
      .hold_req_i   (hold_req),
      .xd_i         (xd_i),
      .req_ready_o  (req_ready_o),
      .rsp_valid_o  (rsp_valid_o),
      .rsp_err_o    (rsp_err_o),
      .rsp_rdata_o  (rsp_rdata_o),
      .xa_o         (xa_o),
      .xd_o         (xd_o),
      .xd_oe_o      (xd_oe_o),
      .bus_oe_o     (bus_oe_o),
      .cs01_n_o     (cs01_n_o),
      .cs2_n_o      (cs2_n_o),
      .cs67_n_o     (cs67_n_o),
      .rd_n_o       (rd_n_o),
      .wr_n_o       (wr_n_o),
      .rnw_o        (rnw_o),
      .holda_n_o    (holda_n_o)
   );

endmodule

// File: rtl/ebz_chk.sv
module ebz_chk (
   input logic clk,
   input logic rst_n,
   input logic rd_n,
   input logic wr_n,
   input logic cs01_n,
   input logic cs2_n,
   input logic cs67_n,
   input logic rnw,
   input logic xd_oe,
   input logic bus_oe,
   input logic holda_n,
   input logic req_ready,
   input logic rsp_valid,
   input logic rsp_err,
   input logic hold_req
);

   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   assert_cs_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!cs01_n, !cs2_n, !cs67_n}));

   assert_strobe_in_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> !(cs01_n && cs2_n && cs67_n));

   assert_hold_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !holda_n |-> (!bus_oe && !xd_oe));

   assert_holda_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(holda_n) |-> !$past(hold_req));

   assert_hold_from_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(holda_n) |-> $past(cs01_n && cs2_n && cs67_n));

   assert_rnw_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rnw |-> (xd_oe && rd_n));

   assert_accept_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (holda_n && cs01_n && cs2_n && cs67_n));

   assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid);

endmodule

bind ext_bus_zone_ctrl ebz_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_n      (rd_n_o),
   .wr_n      (wr_n_o),
   .cs01_n    (cs01_n_o),
   .cs2_n     (cs2_n_o),
   .cs67_n    (cs67_n_o),
   .rnw       (rnw_o),
   .xd_oe     (xd_oe_o),
   .bus_oe    (bus_oe_o),
   .holda_n   (holda_n_o),
   .req_ready (req_ready_o),
   .rsp_valid (rsp_valid_o),
   .rsp_err   (rsp_err_o),
   .hold_req  (hold_req)
);

// File: tb/ext_bus_zone_ctrl_tb.sv
`timescale 1ns/1ps
module ext_bus_zone_ctrl_tb;

   localparam int TW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_mode = 1'b0;
   logic        z7_we = 1'b0;
   logic        z7_d = 1'b0;
   logic [31:0] lead_cfg, act_cfg, trail_cfg;
   logic [7:0]  rdy_async;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [2:0]  req_zone = '0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        ready = 1'b1;
   logic        hold_n = 1'b1;
   logic        req_ready, rsp_valid, rsp_err;
   logic [15:0] rsp_rdata, xa, xd_o, xd_i;
   logic        xd_oe, bus_oe, cs01_n, cs2_n, cs67_n, rd_n, wr_n, rnw, holda_n;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   assign xd_i = xa ^ 16'h5A3C;

   ext_bus_zone_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .boot_mode_i(boot_mode), .z7_we_i(z7_we), .z7_d_i(z7_d),
      .lead_cfg_i(lead_cfg), .act_cfg_i(act_cfg), .trail_cfg_i(trail_cfg),
      .rdy_async_i(rdy_async), .req_valid_i(req_valid), .req_ready_o(req_ready),
      .req_write_i(req_write), .req_zone_i(req_zone), .req_addr_i(req_addr),
      .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
      .rsp_rdata_o(rsp_rdata), .xa_o(xa), .xd_o(xd_o), .xd_i(xd_i), .xd_oe_o(xd_oe),
      .bus_oe_o(bus_oe), .cs01_n_o(cs01_n), .cs2_n_o(cs2_n), .cs67_n_o(cs67_n),
      .rd_n_o(rd_n), .wr_n_o(wr_n), .rnw_o(rnw), .ready_i(ready), .hold_n_i(hold_n),
      .holda_n_o(holda_n)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int eff(input logic [31:0] v, input int z);
      int x;
      x = int'(v[z*TW +: TW]);
      return (x == 0) ? 1 : x;
   endfunction

   function automatic int grp_of(input int z);
      if (z == 0 || z == 1) return 1;
      if (z == 2) return 2;
      if (z == 6 || z == 7) return 3;
      return 0;
   endfunction

   // Behavioural reference: phase 0 idle, 1 lead, 2 active, 3 trail, 4 hold
   int          m_ph, m_cnt, m_z, m_act, m_trl;
   bit          m_w, m_asy, m_z7, m_rspv, m_err, m_lastw;
   bit          m_h1, m_h2, m_r1, m_r2;
   logic [15:0] m_addr, m_wd, m_rdata;

   always @(posedge clk) begin
      bit hreq, r, nv, ne;
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_z = 0; m_w = 0; m_rspv = 0; m_err = 0; m_lastw = 0;
         m_z7 = boot_mode; m_h1 = 1; m_h2 = 1; m_r1 = 0; m_r2 = 0; m_rdata = '0;
      end else begin
         hreq = !m_h2;
         nv = 0; ne = 0;
         case (m_ph)
            0: if (req_valid) begin
                  if (grp_of(int'(req_zone)) != 0 && !(req_zone == 3'd7 && !m_z7)) begin
                     m_z = int'(req_zone); m_w = req_write; m_addr = req_addr; m_wd = req_wdata;
                     m_cnt = eff(lead_cfg, m_z); m_act = eff(act_cfg, m_z);
                     m_trl = eff(trail_cfg, m_z); m_asy = rdy_async[m_z]; m_ph = 1;
                  end else begin
                     nv = 1; ne = 1;
                  end
               end else if (hreq) m_ph = 4;
            1: if (m_cnt == 1) begin m_ph = 2; m_cnt = m_act; end else m_cnt--;
            2: if (m_cnt > 1) m_cnt--;
               else begin
                  r = m_asy ? m_r2 : ready;
                  if (r) begin
                     if (!m_w) m_rdata = xd_i;
                     m_ph = 3; m_cnt = m_trl;
                  end
               end
            3: if (m_cnt == 1) begin m_ph = 0; nv = 1; m_lastw = m_w; end else m_cnt--;
            4: if (!hreq) m_ph = 0;
            default: m_ph = 0;
         endcase
         m_rspv = nv; m_err = ne;
         if (z7_we) m_z7 = z7_d;
         m_h2 = m_h1; m_h1 = hold_n; m_r2 = m_r1; m_r1 = ready;
      end
   end

   // Compare on every clock
   always @(negedge clk) begin
      bit busy;
      int g;
      if (rst_n && !finished) begin
         busy = (m_ph >= 1 && m_ph <= 3);
         g = busy ? grp_of(m_z) : 0;
         check(cs01_n == !(g == 1), "R4", "cs01_n", cs01_n, !(g == 1));
         check(cs2_n == !(g == 2), "R4", "cs2_n", cs2_n, !(g == 2));
         check(cs67_n == !(g == 3), "R4", "cs67_n", cs67_n, !(g == 3));
         check(rd_n == !(m_ph == 2 && !m_w), "R5", "rd_n", rd_n, !(m_ph == 2 && !m_w));
         check(wr_n == !(m_ph == 2 && m_w), "R5", "wr_n", wr_n, !(m_ph == 2 && m_w));
         check(rnw == !(busy && m_w), "R7", "rnw", rnw, !(busy && m_w));
         check(xd_oe == (busy && m_w), "R10", "xd_oe", xd_oe, busy && m_w);
         check(bus_oe == (m_ph != 4), "R2", "bus_oe", bus_oe, m_ph != 4);
         check(holda_n == (m_ph != 4), "R2", "holda_n", holda_n, m_ph != 4);
         check(req_ready == (m_ph == 0), "R9", "req_ready", req_ready, m_ph == 0);
         check(rsp_valid == m_rspv, "R10", "rsp_valid", rsp_valid, m_rspv);
         check(rsp_err == m_err, "R11", "rsp_err", rsp_err, m_err);
         if (busy) check(xa == m_addr, "R4", "xa", xa, m_addr);
         if (busy && m_w) check(xd_o == m_wd, "R10", "xd_o", xd_o, m_wd);
         if (m_rspv && !m_err && !m_lastw)
            check(rsp_rdata == m_rdata, "R10", "rsp_rdata", rsp_rdata, m_rdata);
      end
   end

   task automatic do_access(input int z, input bit w, input logic [15:0] a, input logic [15:0] d,
                            input int rdy_at, output int cs_c, output int st_c,
                            output logic [15:0] rd, output bit err);
      @(negedge clk);
      req_valid = 1; req_zone = 3'(z); req_write = w; req_addr = a; req_wdata = d;
      if (rdy_at >= 0) ready = 0;
      @(negedge clk);
      req_valid = 0;
      cs_c = 0; st_c = 0; err = 0; rd = '0;
      for (int i = 0; i < 300; i++) begin
         if (!(cs01_n && cs2_n && cs67_n)) cs_c++;
         if (!rd_n || !wr_n) begin
            st_c++;
            if (st_c == rdy_at) ready = 1;
         end
         if (rsp_valid) begin
            rd = rsp_rdata; err = rsp_err;
            break;
         end
         @(negedge clk);
      end
      ready = 1;
   endtask

   initial begin
      #4000000;
      if (!finished) begin
         finished = 1;
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int cs_c, st_c, k;
      logic [15:0] rd;
      bit err, bad;
      // zone z fields at [z*4 +: 4]
      lead_cfg  = 32'h0000_0000; act_cfg = 32'h0000_0000; trail_cfg = 32'h0000_0000;
      lead_cfg [0 +: 4] = 4'd1; act_cfg [0 +: 4] = 4'd1; trail_cfg [0 +: 4] = 4'd1;
      lead_cfg [4 +: 4] = 4'd0; act_cfg [4 +: 4] = 4'd2; trail_cfg [4 +: 4] = 4'd0;
      lead_cfg [8 +: 4] = 4'd2; act_cfg [8 +: 4] = 4'd3; trail_cfg [8 +: 4] = 4'd2;
      lead_cfg[24 +: 4] = 4'd3; act_cfg[24 +: 4] = 4'd2; trail_cfg[24 +: 4] = 4'd1;
      lead_cfg[28 +: 4] = 4'd1; act_cfg[28 +: 4] = 4'd4; trail_cfg[28 +: 4] = 4'd3;
      rdy_async = 8'b0100_0000;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(req_ready && holda_n && cs01_n && cs2_n && cs67_n && rnw && rd_n && wr_n,
            "R9", "reset idle", {req_ready, holda_n, cs01_n, cs2_n, cs67_n}, 5'h1f);

      do_access(0, 0, 16'h0010, 16'h0, -1, cs_c, st_c, rd, err);
      check(cs_c == 3, "R4", "zone0 select cycles", cs_c, 3);
      check(st_c == 1, "R5", "zone0 strobe cycles", st_c, 1);
      check(rd == (16'h0010 ^ 16'h5A3C), "R10", "zone0 read data", rd, 16'h0010 ^ 16'h5A3C);

      do_access(1, 1, 16'h0123, 16'hBEEF, -1, cs_c, st_c, rd, err);
      check(cs_c == 4, "R5", "zone1 zero fields select cycles", cs_c, 4);
      check(st_c == 2, "R5", "zone1 strobe cycles", st_c, 2);

      do_access(2, 1, 16'h2222, 16'h1234, -1, cs_c, st_c, rd, err);
      check(cs_c == 7, "R4", "zone2 select cycles", cs_c, 7);
      check(st_c == 3, "R5", "zone2 strobe cycles", st_c, 3);

      do_access(2, 0, 16'h2A00, 16'h0, 5, cs_c, st_c, rd, err);
      check(st_c == 5, "R8", "sync ready stretch", st_c, 5);
      check(rd == (16'h2A00 ^ 16'h5A3C), "R10", "stretched read data", rd, 16'h2A00 ^ 16'h5A3C);

      do_access(6, 0, 16'h6600, 16'h0, -1, cs_c, st_c, rd, err);
      check(cs_c == 6 && st_c == 2, "R4", "zone6 select cycles", cs_c, 6);

      do_access(6, 0, 16'h6601, 16'h0, 4, cs_c, st_c, rd, err);
      check(st_c == 6, "R8", "async ready stretch", st_c, 6);

      do_access(3, 1, 16'h3000, 16'h5555, -1, cs_c, st_c, rd, err);
      check(err && cs_c == 0, "R11", "zone3 rejected", {err, 4'(cs_c)}, 5'h10);
      do_access(5, 0, 16'h5000, 16'h0, -1, cs_c, st_c, rd, err);
      check(err && cs_c == 0, "R11", "zone5 rejected", {err, 4'(cs_c)}, 5'h10);

      do_access(7, 0, 16'h7000, 16'h0, -1, cs_c, st_c, rd, err);
      check(err && cs_c == 0, "R1", "zone7 off after reset", {err, 4'(cs_c)}, 5'h10);
      @(negedge clk); boot_mode = 1;
      repeat (2) @(negedge clk);
      do_access(7, 0, 16'h7001, 16'h0, -1, cs_c, st_c, rd, err);
      check(err && cs_c == 0, "R1", "pin ignored after reset", {err, 4'(cs_c)}, 5'h10);
      @(negedge clk); z7_we = 1; z7_d = 1;
      @(negedge clk); z7_we = 0;
      do_access(7, 1, 16'h7002, 16'hC0DE, -1, cs_c, st_c, rd, err);
      check(!err && cs_c == 8 && st_c == 4, "R1", "zone7 on after write", cs_c, 8);

      // hold raised during a write
      @(negedge clk);
      req_valid = 1; req_zone = 3'd2; req_write = 1; req_addr = 16'h2B00; req_wdata = 16'hA11A;
      @(negedge clk);
      req_valid = 0; hold_n = 0;
      bad = 0;
      for (int i = 0; i < 50 && !rsp_valid; i++) begin
         if (!holda_n) bad = 1;
         @(negedge clk);
      end
      check(!bad && rsp_valid, "R3", "access finished before hold", bad, 0);
      @(negedge clk);
      check(!holda_n && !bus_oe && !xd_oe, "R2", "hold granted", {holda_n, bus_oe, xd_oe}, 3'b000);
      req_valid = 1; req_zone = 3'd0; req_write = 0; req_addr = 16'h0042;
      repeat (3) @(negedge clk);
      check(!req_ready && cs01_n && !holda_n, "R9", "no accept in hold", req_ready, 0);
      hold_n = 1;
      k = 0;
      while (!req_ready && k < 10) begin @(negedge clk); k++; end
      check(holda_n && k == 3, "R2", "hold release delay", k, 3);
      @(negedge clk);
      req_valid = 0;
      for (int i = 0; i < 50 && !rsp_valid; i++) @(negedge clk);
      check(rsp_valid && rsp_rdata == (16'h0042 ^ 16'h5A3C), "R10", "read after hold",
            rsp_rdata, 16'h0042 ^ 16'h5A3C);

      // request valid together with hold request while idle: request served first
      @(negedge clk);
      req_valid = 1; req_zone = 3'd1; req_write = 1; req_addr = 16'h0777; req_wdata = 16'h0F0F;
      hold_n = 0;
      @(negedge clk);
      req_valid = 0;
      check(!cs01_n && holda_n, "R3", "request beats hold", cs01_n, 0);
      for (int i = 0; i < 50 && holda_n; i++) @(negedge clk);
      check(!holda_n && cs01_n, "R2", "hold after request", holda_n, 0);
      hold_n = 1;
      repeat (6) @(negedge clk);
      check(holda_n && req_ready, "R2", "released", holda_n, 1);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule